// File: doc/BRIEF.md
# Sample Playback Audio Channel

One voice of a sampled-sound engine. The channel reads 16-bit words from memory over a request/acknowledge read port. It plays each word as two signed 8-bit samples, high byte first. A period counter spaces the samples, and a volume scaler turns each sample into a signed 14-bit value for an external DAC.

Software programs the channel through a small write port. The programmable values are an 18-bit buffer start address (split into an upper and a lower half), a block length in words, a sample period, a volume, and a data word that bypasses memory. While fetching is enabled, the channel loops over the buffer without pause. At the end of every block, the running pointer and word count reload from the programmed start and length. The programmed start address never moves. An interrupt request rises when the final word of a block is taken for playback. It stays raised until it is cleared.

The start of each data fetch is gated by `dma_en`. Memory arbitration and the DAC itself sit outside the block.

Top module: `pcm_voice`

## Requirements
- R1: A write with `cfg_sel`=0 sets the upper start-address bits from `cfg_wdata[1:0]`, and `cfg_sel`=1 sets the lower 16 bits. Bit 0 of the lower half is ignored, so fetches are word aligned. When `dma_en` rises, the first fetch goes to the programmed start address.
- R2: Within a block, fetch addresses step by 2 for as many words as the length register (`cfg_sel`=2) holds. The fetch after the last word of a block goes to the start address again, which fetches never modify.
- R3: A length of 0 behaves as a length of 1, so every fetch goes to the start address and every word ends a block.
- R4: When the channel is idle and a word enters the empty buffer, its high byte reaches the output on the next clock edge. Each following sample appears exactly `period` clock cycles after the previous one (`cfg_sel`=3).
- R5: A period value below 124 is stored as 124.
- R6: The volume word (`cfg_sel`=4) gives level = bits 5..0, or 64 when bit 6 is set. Bits 15..7 have no effect. `dac_out` equals the signed sample times the level, as a 14-bit two's-complement value.
- R7: Each word is played as two two's-complement bytes, bits 15..8 first, then bits 7..0.
- R8: A write with `cfg_sel`=5 loads the data word directly into the buffer. It is played like a fetched word but never raises the interrupt request.
- R9: `irq` rises on the same edge where the high byte of a block's last fetched word reaches the output. It then stays high until `irq_clr` is asserted; a new set in the same cycle wins over the clear.
- R10: `mem_req` is asserted only while `dma_en` is high and the word buffer is empty. `mem_addr` holds steady while a request waits for `mem_ack`.
- R11: After reset, `dac_out` is 0, `irq` is 0 and `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, one cycle per color clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 16 | Register write data |
| dma_en | input | 1 | Allows memory fetches; a rising edge restarts at the start address |
| irq_clr | input | 1 | Clears the block-done interrupt request |
| mem_req | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 16 | Read data word |
| dac_out | output | 14 | Scaled signed sample for the DAC |
| irq | output | 1 | Block-done interrupt request |

## Verification
When the channel is idle, a word written into the buffer reaches `dac_out` one edge later. The low byte follows exactly `period` edges after that. The bench therefore samples one cycle early and at the due cycle, and checks that the value has not yet changed and then has. In a fetch run, counting from the edge that sees `dma_en`, the fetch handshake, the period counter and three words of playback put the interrupt exactly 498 edges later. The bench checks `irq` low one cycle before and high at that edge, together with the sample it carries. All sampling is done on falling edges, so every registered output is settled.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;
  localparam int WORD_W = 16;
  localparam int SAMP_W = 8;
  localparam int LVL_W  = 7;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_START_HI = 3'd0,
    SEL_START_LO = 3'd1,
    SEL_LENGTH   = 3'd2,
    SEL_PERIOD   = 3'd3,
    SEL_VOLUME   = 3'd4,
    SEL_DATA     = 3'd5
  } cfg_sel_e;
endpackage

// File: rtl/pcm_voice_regs.sv
module pcm_voice_regs
  import pcm_voice_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int LEN_W      = 16,
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 124
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  blk_len,
  output logic [PER_W-1:0]  period,
  output logic [LVL_W-1:0]  vol_lvl
);
  localparam int HI_W = ADDR_W - WORD_W;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic [WORD_W-1:1] lo_q, lo_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic [LVL_W-1:0]  vol_q, vol_d;
  logic en_hi, en_lo, en_len, en_per, en_vol;

  always_comb begin
    en_hi  = cfg_we && (cfg_sel == SEL_START_HI);
    en_lo  = cfg_we && (cfg_sel == SEL_START_LO);
    en_len = cfg_we && (cfg_sel == SEL_LENGTH);
    en_per = cfg_we && (cfg_sel == SEL_PERIOD);
    en_vol = cfg_we && (cfg_sel == SEL_VOLUME);
    hi_d   = cfg_wdata[HI_W-1:0];
    lo_d   = cfg_wdata[WORD_W-1:1];
    len_d  = cfg_wdata[LEN_W-1:0];
    vol_d  = cfg_wdata[LVL_W-1:0];
    if (cfg_wdata[PER_W-1:0] < PER_W'(MIN_PERIOD))
      per_d = PER_W'(MIN_PERIOD);
    else
      per_d = cfg_wdata[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      len_q <= '0;
      per_q <= PER_W'(MIN_PERIOD);
      vol_q <= '0;
    end else begin
      if (en_hi)  hi_q  <= hi_d;
      if (en_lo)  lo_q  <= lo_d;
      if (en_len) len_q <= len_d;
      if (en_per) per_q <= per_d;
      if (en_vol) vol_q <= vol_d;
    end
  end

  always_comb begin
    start_addr = {hi_q, lo_q, 1'b0};
    blk_len    = (len_q == '0) ? LEN_W'(1) : len_q;
    period     = per_q;
    vol_lvl    = vol_q[LVL_W-1] ? LVL_W'(1 << (LVL_W - 1)) : {1'b0, vol_q[LVL_W-2:0]};
  end
endmodule

// File: rtl/pcm_voice_fetch.sv
module pcm_voice_fetch #(
  parameter int ADDR_W = 18,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic              buf_full,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fill_stb,
  output logic              fill_last
);
  logic              active_q, active_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              restart, ptr_en;

  always_comb begin
    mem_req   = active_q && dma_en && !buf_full;
    mem_addr  = ptr_q;
    fill_stb  = mem_req && mem_ack;
    fill_last = (rem_q == LEN_W'(1));
    restart   = dma_en && !active_q;
    active_d  = dma_en;
    ptr_en    = restart || fill_stb;
    ptr_d     = ptr_q;
    rem_d     = rem_q;
    if (restart || (fill_stb && fill_last)) begin
      ptr_d = start_addr;
      rem_d = blk_len;
    end else if (fill_stb) begin
      ptr_d = ptr_q + ADDR_W'(2);
      rem_d = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      rem_q    <= '0;
    end else begin
      active_q <= active_d;
      if (ptr_en) begin
        ptr_q <= ptr_d;
        rem_q <= rem_d;
      end
    end
  end
endmodule

// File: rtl/pcm_voice_play.sv
module pcm_voice_play
  import pcm_voice_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int OUT_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_stb,
  input  logic [WORD_W-1:0] fill_word,
  input  logic              fill_last,
  input  logic              cpu_wr,
  input  logic [WORD_W-1:0] cpu_word,
  input  logic [PER_W-1:0]  period,
  input  logic [LVL_W-1:0]  vol_lvl,
  input  logic              irq_clr,
  output logic              buf_full,
  output logic [OUT_W-1:0]  dac_out,
  output logic              irq
);
  localparam int PROD_W = 2 * WORD_W;

  logic [WORD_W-1:0] buf_q, buf_d;
  logic              full_q, full_d, last_q, last_d;
  logic [SAMP_W-1:0] lo_q, lo_d, samp_q, samp_d;
  logic              pend_q, pend_d;
  logic [PER_W-1:0]  pcnt_q, pcnt_d;
  logic              irq_q, irq_d;
  logic              tick, consume;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    tick    = (pcnt_q == '0) && (pend_q || full_q);
    consume = tick && !pend_q;
    pcnt_d  = pcnt_q;
    if (tick)
      pcnt_d = period - PER_W'(1);
    else if (pcnt_q != '0)
      pcnt_d = pcnt_q - PER_W'(1);

    samp_d = samp_q;
    lo_d   = lo_q;
    pend_d = pend_q;
    full_d = full_q;
    buf_d  = buf_q;
    last_d = last_q;
    if (tick) begin
      if (pend_q) begin
        samp_d = lo_q;
        pend_d = 1'b0;
      end else begin
        samp_d = buf_q[WORD_W-1:SAMP_W];
        lo_d   = buf_q[SAMP_W-1:0];
        pend_d = 1'b1;
        full_d = 1'b0;
      end
    end
    if (cpu_wr) begin
      buf_d  = cpu_word;
      full_d = 1'b1;
      last_d = 1'b0;
    end else if (fill_stb) begin
      buf_d  = fill_word;
      full_d = 1'b1;
      last_d = fill_last;
    end

    irq_d = irq_q;
    if (irq_clr)
      irq_d = 1'b0;
    if (consume && last_q)
      irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
      lo_q   <= '0;
      pend_q <= 1'b0;
      samp_q <= '0;
      pcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      last_q <= last_d;
      lo_q   <= lo_d;
      pend_q <= pend_d;
      samp_q <= samp_d;
      pcnt_q <= pcnt_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    prod     = $signed({{(PROD_W-SAMP_W){samp_q[SAMP_W-1]}}, samp_q})
             * $signed({{(PROD_W-LVL_W){1'b0}}, vol_lvl});
    dac_out  = prod[OUT_W-1:0];
    buf_full = full_q;
    irq      = irq_q;
  end
endmodule

// File: rtl/pcm_voice.sv
module pcm_voice
  import pcm_voice_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int MIN_PERIOD = 124
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              dma_en,
  input  logic              irq_clr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic [13:0]       dac_out,
  output logic              irq
);
  localparam int LEN_W = WORD_W;
  localparam int PER_W = WORD_W;
  localparam int OUT_W = SAMP_W + LVL_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  blk_len;
  logic [PER_W-1:0]  period;
  logic [LVL_W-1:0]  vol_lvl;
  logic              buf_full, fill_stb, fill_last, cpu_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];
  assign cpu_wr     = cfg_we && (cfg_sel == SEL_DATA);

  pcm_voice_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)
  ) regs_i (
    .clk(clk), .rst_n(rst_core_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start_addr(start_addr), .blk_len(blk_len),
    .period(period), .vol_lvl(vol_lvl)
  );

  pcm_voice_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) fetch_i (
    .clk(clk), .rst_n(rst_core_n), .dma_en(dma_en), .start_addr(start_addr),
    .blk_len(blk_len), .buf_full(buf_full), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .fill_stb(fill_stb),
    .fill_last(fill_last)
  );

  pcm_voice_play #(.PER_W(PER_W), .OUT_W(OUT_W)) play_i (
    .clk(clk), .rst_n(rst_core_n), .fill_stb(fill_stb), .fill_word(mem_rdata),
    .fill_last(fill_last), .cpu_wr(cpu_wr), .cpu_word(cfg_wdata),
    .period(period), .vol_lvl(vol_lvl), .irq_clr(irq_clr),
    .buf_full(buf_full), .dac_out(dac_out), .irq(irq)
  );
endmodule

// File: rtl/pcm_voice_chk.sv
module pcm_voice_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_en,
  input logic              irq_clr,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              irq
);
  // R10: no request without permission to fetch
  assert_req_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> dma_en);

  // R10: a waiting request keeps its address
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr)));

  // R10: an accepted word fills the buffer, so the request drops
  assert_req_drops_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req);

  // R1: fetches are word aligned
  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0));

  // R9: the request stays until cleared
  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind pcm_voice pcm_voice_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_clr(irq_clr),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .irq(irq)
);

// File: tb/pcm_voice_tb_top.sv
module pcm_voice_tb_top;
  localparam int NV = 6;
  localparam logic [15:0] VOLW [NV] = '{16'h0040, 16'h0000, 16'hFF85, 16'h007F, 16'h0021, 16'h0001};
  localparam logic [15:0] DATW [NV] = '{16'h7F80, 16'h1234, 16'h01FF, 16'h8001, 16'hC03E, 16'h55AA};
  localparam int          LVLS [NV] = '{64, 0, 5, 64, 33, 1};

  logic        clk, rst_n, cfg_we, dma_en, irq_clr, mem_req, mem_ack, irq;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata, mem_rdata;
  logic [17:0] mem_addr;
  logic [13:0] dac_out;

  int checks = 0;
  int fails  = 0;
  logic [17:0] log_a [16];
  int log_n = 0;

  pcm_voice dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dma_en(dma_en), .irq_clr(irq_clr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .dac_out(dac_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] memf(logic [17:0] a);
    return {a[7:0] ^ 8'h90, a[7:0] ^ 8'h0F};
  endfunction

  function automatic logic [13:0] scaled(logic [7:0] b, int lvl);
    int v;
    v = $signed(b) * lvl;
    return v[13:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // play one directly written word and check both samples at their due cycles
  task automatic play_word(input logic [15:0] w, input int lvl, input int per, input string req);
    cfg_write(3'd5, w);
    @(negedge clk);
    check(dac_out == scaled(w[15:8], lvl), req, {18'd0, dac_out}, {18'd0, scaled(w[15:8], lvl)});
    idle(per - 1);
    check(dac_out == scaled(w[15:8], lvl), req, {18'd0, dac_out}, {18'd0, scaled(w[15:8], lvl)});
    @(negedge clk);
    check(dac_out == scaled(w[7:0], lvl), req, {18'd0, dac_out}, {18'd0, scaled(w[7:0], lvl)});
  endtask

  // memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack   = mem_req;
      mem_rdata = memf(mem_addr);
      if (mem_req) begin
        if (log_n < 16) log_a[log_n] = mem_addr;
        log_n++;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    dma_en = 1'b0; irq_clr = 1'b0;
    idle(4);
    // R11 reset state
    check(dac_out == 14'd0, "R11 dac", {18'd0, dac_out}, 32'd0);
    check(irq == 1'b0, "R11 irq", {31'd0, irq}, 32'd0);
    check(mem_req == 1'b0, "R11 req", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    idle(4);

    // R6 R7 vector table of volume/data pairs at the minimum period
    for (int i = 0; i < NV; i++) begin
      cfg_write(3'd4, VOLW[i]);
      play_word(DATW[i], LVLS[i], 124, "R6/R7 vector");
      check(irq == 1'b0, "R8 no irq on direct data", {31'd0, irq}, 32'd0);
      idle(130);
    end

    // R4 longer period
    cfg_write(3'd4, 16'h0001);
    cfg_write(3'd3, 16'd200);
    play_word(16'h1E9C, 1, 200, "R4 period 200");
    idle(260);

    // R5 clamp
    cfg_write(3'd3, 16'd10);
    play_word(16'hA05F, 1, 124, "R5 clamp to 124");
    idle(130);

    // R1 R2 R9 fetch run: start 0x10100, three words
    cfg_write(3'd3, 16'd124);
    cfg_write(3'd0, 16'h0001);
    cfg_write(3'd1, 16'h0100);
    cfg_write(3'd2, 16'd3);
    log_n = 0;
    @(negedge clk);
    dma_en = 1'b1;
    idle(498);
    check(irq == 1'b0, "R9 irq not early", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check(irq == 1'b1, "R9 irq on last word", {31'd0, irq}, 32'd1);
    check(dac_out == scaled(memf(18'h10104) >> 8, 1), "R9 sample with irq",
          {18'd0, dac_out}, {18'd0, scaled(memf(18'h10104) >> 8, 1)});
    idle(3);
    check(log_n >= 4, "R2 fetch count", log_n, 32'd4);
    check(log_a[0] == 18'h10100, "R1 first fetch", {14'd0, log_a[0]}, 32'h10100);
    check(log_a[1] == 18'h10102, "R2 second fetch", {14'd0, log_a[1]}, 32'h10102);
    check(log_a[2] == 18'h10104, "R2 third fetch", {14'd0, log_a[2]}, 32'h10104);
    check(log_a[3] == 18'h10100, "R2 reload to start", {14'd0, log_a[3]}, 32'h10100);
    idle(5);
    check(irq == 1'b1, "R9 irq held", {31'd0, irq}, 32'd1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(irq == 1'b0, "R9 irq cleared", {31'd0, irq}, 32'd0);

    // R10 no request while disabled
    dma_en = 1'b0;
    idle(3);
    check(mem_req == 1'b0, "R10 req off", {31'd0, mem_req}, 32'd0);
    idle(300);

    // R3 zero length, R1 ignored address bit 0
    cfg_write(3'd0, 16'h0000);
    cfg_write(3'd1, 16'h0201);
    cfg_write(3'd2, 16'h0000);
    log_n = 0;
    @(negedge clk);
    dma_en = 1'b1;
    idle(700);
    check(log_n >= 2, "R3 fetch count", log_n, 32'd2);
    check(log_a[0] == 18'h00200, "R1 bit0 ignored", {14'd0, log_a[0]}, 32'h200);
    check(log_a[1] == 18'h00200, "R3 length zero repeats start", {14'd0, log_a[1]}, 32'h200);
    check(irq == 1'b1, "R3 every word ends block", {31'd0, irq}, 32'd1);
    dma_en = 1'b0;
    idle(3);
    check(mem_req == 1'b0, "R10 req off again", {31'd0, mem_req}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule